// File: doc/BRIEF.md
# Windowed Segment Address Translator

This block turns a process address into a physical store address through a small per-process table of permitted segments. Each table entry describes one segment: whether it is usable, where it starts in physical store, the highest offset that may be touched, and whether writes are allowed. Every segment spans at most 16KiB, so the low 14 bits of any address form the offset into the segment, and the upper bits choose the entry.

There are two ways to choose the entry, and the mode flag picks one for each request. In window mode a 16-bit address is used. Its top two bits pick one of four window registers, and that register names a table entry. In flat mode a 32-bit address is used, and its bits above bit 13 index the table directly. Entry n therefore covers flat bytes n*16KiB up to n*16KiB+16383.

A separate test-mode input bypasses translation entirely, but only the bottom 64KiB may be reached. The table and the window registers are loaded through a simple write port. Results appear one clock after the request.

Top module: `seg_xlate`

## Requirements
- R1: After reset, rsp_valid_o and rsp_fault_o are low, every table entry is invalid, and all four window registers hold entry index 0.
- R2: In window mode (req_flat_i=0, req_test_i=0), vaddr bits 15:14 select a window register. That register's table entry gives the segment, and bits 13:0 are the offset. paddr = entry base + offset. Bits 31:16 are ignored.
- R3: In flat mode (req_flat_i=1, req_test_i=0), the table index is vaddr bits 31:14 and paddr = entry base + vaddr bits 13:0. An index at or above TBL_DEPTH faults.
- R4: Window-mode and flat-mode requests may be issued back to back in any order. Each one is translated according to its own mode flag.
- R5: Access kind is encoded as 2'b00 fetch, 2'b01 read, 2'b10 write; 2'b11 is handled as a read. A fetch in flat mode faults. A fetch in window mode is translated normally.
- R6: With req_test_i=1, translation is bypassed: paddr = vaddr zero-extended, with no fault, when vaddr < 65536. Any vaddr at or above 65536 faults. Test mode overrides the mode flag and the access kind.
- R7: A translated access faults when its entry is invalid, or when its offset exceeds the entry's limit (the limit is the highest permitted offset), or when a write targets an entry whose write-permit bit is 0.
- R8: rsp_valid_o rises exactly one cycle after req_valid_i, and the response reflects that request. When rsp_fault_o is high, rsp_paddr_o is 0. Without a request, rsp_valid_o and rsp_fault_o are low.
- R9: A table or window write takes effect from the following cycle. A request issued in the same cycle as a write is translated with the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Translation request |
| req_vaddr_i | input | 32 | Process address |
| req_kind_i | input | 2 | Access kind (fetch/read/write) |
| req_flat_i | input | 1 | 1 = flat mode, 0 = window mode |
| req_test_i | input | 1 | Test-mode bypass |
| win_we_i | input | 1 | Window register write strobe |
| win_sel_i | input | 2 | Window register to write |
| win_idx_i | input | IDX_W | Table index loaded into the window |
| tbl_we_i | input | 1 | Table entry write strobe |
| tbl_idx_i | input | IDX_W | Table entry to write |
| tbl_valid_i | input | 1 | Entry valid bit |
| tbl_base_i | input | PA_W | Entry physical base |
| tbl_limit_i | input | 14 | Entry highest permitted offset |
| tbl_wr_ok_i | input | 1 | Entry write permit |
| rsp_valid_o | output | 1 | Response valid |
| rsp_paddr_o | output | PA_W | Physical address (0 on fault) |
| rsp_fault_o | output | 1 | Access fault |

## Verification
A wrong window register or a wrong table entry shows up in the cycle right after the next request that uses it, either as a shifted physical address or as a spurious or missing fault. A stale or corrupted permission or limit bit shows only when a request crosses that boundary, so the bench probes offsets exactly at and just past each limit and writes to read-only entries. Ordering errors in the write port appear as a one-request lag, which the same-cycle write-and-request cases expose.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int OFS_W = 14;
  localparam int VA_W  = 32;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int DEPTH = 16,
  parameter int PA_W  = 24,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int OFS_W = seg_xlate_pkg::OFS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_valid_i,
  input  logic [PA_W-1:0]  wr_base_i,
  input  logic [OFS_W-1:0] wr_limit_i,
  input  logic             wr_ok_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic [PA_W-1:0]  rd_base_o,
  output logic [OFS_W-1:0] rd_limit_o,
  output logic             rd_wr_ok_o
);
  logic [DEPTH-1:0]            valid_q;
  logic [DEPTH-1:0][PA_W-1:0]  base_q;
  logic [DEPTH-1:0][OFS_W-1:0] limit_q;
  logic [DEPTH-1:0]            wr_ok_q;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[e] <= 1'b0;
        base_q[e]  <= '0;
        limit_q[e] <= '0;
        wr_ok_q[e] <= 1'b0;
      end else if (we_i && int'(wr_idx_i) == e) begin
        valid_q[e] <= wr_valid_i;
        base_q[e]  <= wr_base_i;
        limit_q[e] <= wr_limit_i;
        wr_ok_q[e] <= wr_ok_i;
      end
    end
  end

  // out-of-range index reads back as an invalid entry
  logic in_range;
  assign in_range   = int'(rd_idx_i) < DEPTH;
  assign rd_valid_o = in_range && valid_q[rd_idx_i];
  assign rd_base_o  = base_q[rd_idx_i];
  assign rd_limit_o = limit_q[rd_idx_i];
  assign rd_wr_ok_o = wr_ok_q[rd_idx_i];

  p_tbl_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (valid_q[$past(wr_idx_i)] == $past(wr_valid_i)) &&
             (base_q[$past(wr_idx_i)] == $past(wr_base_i)));
endmodule

// File: rtl/seg_win_regs.sv
module seg_win_regs #(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [1:0]       rd_sel_i,
  output logic [IDX_W-1:0] rd_idx_o
);
  logic [3:0][IDX_W-1:0] win_q;

  for (genvar w = 0; w < 4; w++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          win_q[w] <= '0;
      else if (we_i && wr_sel_i == 2'(w))   win_q[w] <= wr_idx_i;
    end
  end

  assign rd_idx_o = win_q[rd_sel_i];

  p_win_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> win_q[$past(wr_sel_i)] == $past(wr_idx_i));
endmodule

// File: rtl/seg_check.sv
module seg_check #(
  parameter int PA_W = 24,
  localparam int OFS_W = seg_xlate_pkg::OFS_W
) (
  input  seg_xlate_pkg::acc_kind_e kind_i,
  input  logic [OFS_W-1:0]         ofs_i,
  input  logic                     ent_valid_i,
  input  logic [PA_W-1:0]          ent_base_i,
  input  logic [OFS_W-1:0]         ent_limit_i,
  input  logic                     ent_wr_ok_i,
  output logic                     fault_o,
  output logic [PA_W-1:0]          paddr_o
);
  import seg_xlate_pkg::*;

  logic over_limit, wr_denied;
  assign over_limit = ofs_i > ent_limit_i;
  assign wr_denied  = (kind_i == ACC_WRITE) && !ent_wr_ok_i;
  assign fault_o    = !ent_valid_i || over_limit || wr_denied;
  assign paddr_o    = ent_base_i + PA_W'(ofs_i);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int TBL_DEPTH = 16,
  parameter int PA_W      = 24,
  localparam int IDX_W    = $clog2(TBL_DEPTH),
  localparam int OFS_W    = seg_xlate_pkg::OFS_W,
  localparam int VA_W     = seg_xlate_pkg::VA_W,
  localparam int HI_W     = VA_W - OFS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic [1:0]       req_kind_i,
  input  logic             req_flat_i,
  input  logic             req_test_i,
  input  logic             win_we_i,
  input  logic [1:0]       win_sel_i,
  input  logic [IDX_W-1:0] win_idx_i,
  input  logic             tbl_we_i,
  input  logic [IDX_W-1:0] tbl_idx_i,
  input  logic             tbl_valid_i,
  input  logic [PA_W-1:0]  tbl_base_i,
  input  logic [OFS_W-1:0] tbl_limit_i,
  input  logic             tbl_wr_ok_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic             rsp_fault_o
);
  import seg_xlate_pkg::*;

  localparam logic [HI_W-1:0] DEPTH_V = HI_W'(TBL_DEPTH);

  acc_kind_e        kind;
  logic [IDX_W-1:0] win_idx, tbl_idx;
  logic [HI_W-1:0]  flat_hi;
  logic             flat_oob, flat_fetch;
  logic             ent_valid, ent_wr_ok;
  logic [PA_W-1:0]  ent_base, chk_paddr, test_paddr;
  logic [OFS_W-1:0] ent_limit;
  logic             chk_fault, test_fault;
  logic             nxt_fault;
  logic [PA_W-1:0]  nxt_paddr;

  assign kind    = acc_kind_e'(req_kind_i);
  assign flat_hi = req_vaddr_i[VA_W-1:OFS_W];

  seg_win_regs #(.IDX_W(IDX_W)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (win_we_i),
    .wr_sel_i (win_sel_i),
    .wr_idx_i (win_idx_i),
    .rd_sel_i (req_vaddr_i[15:14]),
    .rd_idx_o (win_idx)
  );

  assign tbl_idx = req_flat_i ? flat_hi[IDX_W-1:0] : win_idx;

  seg_table #(.DEPTH(TBL_DEPTH), .PA_W(PA_W)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (tbl_we_i),
    .wr_idx_i   (tbl_idx_i),
    .wr_valid_i (tbl_valid_i),
    .wr_base_i  (tbl_base_i),
    .wr_limit_i (tbl_limit_i),
    .wr_ok_i    (tbl_wr_ok_i),
    .rd_idx_i   (tbl_idx),
    .rd_valid_o (ent_valid),
    .rd_base_o  (ent_base),
    .rd_limit_o (ent_limit),
    .rd_wr_ok_o (ent_wr_ok)
  );

  seg_check #(.PA_W(PA_W)) u_chk (
    .kind_i      (kind),
    .ofs_i       (req_vaddr_i[OFS_W-1:0]),
    .ent_valid_i (ent_valid),
    .ent_base_i  (ent_base),
    .ent_limit_i (ent_limit),
    .ent_wr_ok_i (ent_wr_ok),
    .fault_o     (chk_fault),
    .paddr_o     (chk_paddr)
  );

  // flat-mode specific rejections
  assign flat_oob   = req_flat_i && (flat_hi >= DEPTH_V);
  assign flat_fetch = req_flat_i && (kind == ACC_FETCH);

  // test-mode bypass: bottom 64KiB only
  assign test_fault = |req_vaddr_i[VA_W-1:16];
  assign test_paddr = PA_W'(req_vaddr_i[15:0]);

  always_comb begin
    if (req_test_i) nxt_fault = test_fault;
    else            nxt_fault = flat_oob || flat_fetch || chk_fault;
    if (nxt_fault)       nxt_paddr = '0;
    else if (req_test_i) nxt_paddr = test_paddr;
    else                 nxt_paddr = chk_paddr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_paddr_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_fault_o <= req_valid_i && nxt_fault;
      rsp_paddr_o <= req_valid_i ? nxt_paddr : '0;
    end
  end

  p_flat_fetch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_flat_i && !req_test_i && req_kind_i == 2'b00 |=> rsp_fault_o);

  p_flat_oob_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_flat_i && !req_test_i && (req_vaddr_i[31:14] >= DEPTH_V) |=> rsp_fault_o);

  p_test_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_test_i && (req_vaddr_i[31:16] != 16'h0) |=> rsp_fault_o);

  p_test_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_test_i && (req_vaddr_i[31:16] == 16'h0) |=>
      !rsp_fault_o && rsp_paddr_o == PA_W'($past(req_vaddr_i[15:0])));

  p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && !rsp_fault_o);

  p_fault_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> rsp_valid_o && rsp_paddr_o == '0);
endmodule

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb;
  localparam int DEPTH = 16;
  localparam int PA_W  = 24;
  localparam int IDX_W = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_valid_i = 1'b0;
  logic [31:0]      req_vaddr_i = '0;
  logic [1:0]       req_kind_i = '0;
  logic             req_flat_i = 1'b0;
  logic             req_test_i = 1'b0;
  logic             win_we_i = 1'b0;
  logic [1:0]       win_sel_i = '0;
  logic [IDX_W-1:0] win_idx_i = '0;
  logic             tbl_we_i = 1'b0;
  logic [IDX_W-1:0] tbl_idx_i = '0;
  logic             tbl_valid_i = 1'b0;
  logic [PA_W-1:0]  tbl_base_i = '0;
  logic [13:0]      tbl_limit_i = '0;
  logic             tbl_wr_ok_i = 1'b0;
  logic             rsp_valid_o;
  logic [PA_W-1:0]  rsp_paddr_o;
  logic             rsp_fault_o;

  always #4 clk_i = ~clk_i;

  seg_xlate #(.TBL_DEPTH(DEPTH), .PA_W(PA_W)) u_dut (.*);

  int checks = 0;
  int failures = 0;

  // shadow configuration written by the bench
  logic             sh_v   [DEPTH];
  logic [PA_W-1:0]  sh_base[DEPTH];
  logic [13:0]      sh_lim [DEPTH];
  logic             sh_wr  [DEPTH];
  logic [IDX_W-1:0] sh_win [4];

  typedef struct packed { logic fault; logic [PA_W-1:0] pa; logic [7:0] req; } exp_t;
  exp_t exp_q[$];

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [31:0] va, input logic [1:0] kind,
                                 input logic flat, input logic test, input logic [7:0] rq);
    exp_t e;
    int idx;
    e.req = rq; e.fault = 1'b0; e.pa = '0;
    if (test) begin
      e.fault = (va >= 32'h1_0000);
      if (!e.fault) e.pa = PA_W'(va[15:0]);
      return e;
    end
    if (flat) begin
      idx = int'(va[31:14]);
      if (kind == 2'b00 || idx >= DEPTH) begin e.fault = 1'b1; return e; end
    end else idx = int'(sh_win[va[15:14]]);
    if (!sh_v[idx] || va[13:0] > sh_lim[idx] || (kind == 2'b10 && !sh_wr[idx])) e.fault = 1'b1;
    else e.pa = sh_base[idx] + PA_W'(va[13:0]);
    return e;
  endfunction

  task automatic tick();
    @(negedge clk_i);
    req_valid_i = 1'b0; win_we_i = 1'b0; tbl_we_i = 1'b0; req_test_i = 1'b0;
  endtask

  // issue a request in the current cycle and push its expected result
  task automatic set_req(input logic [31:0] va, input logic [1:0] kind,
                         input logic flat, input logic test, input logic [7:0] rq);
    req_valid_i = 1'b1; req_vaddr_i = va; req_kind_i = kind;
    req_flat_i = flat; req_test_i = test;
    exp_q.push_back(model(va, kind, flat, test, rq));
  endtask

  task automatic set_win(input logic [1:0] sel, input logic [IDX_W-1:0] idx);
    win_we_i = 1'b1; win_sel_i = sel; win_idx_i = idx;
    sh_win[sel] = idx;
  endtask

  task automatic set_tbl(input int idx, input logic v, input logic [PA_W-1:0] b,
                         input logic [13:0] lim, input logic w);
    tbl_we_i = 1'b1; tbl_idx_i = IDX_W'(idx); tbl_valid_i = v;
    tbl_base_i = b; tbl_limit_i = lim; tbl_wr_ok_i = w;
    sh_v[idx] = v; sh_base[idx] = b; sh_lim[idx] = lim; sh_wr[idx] = w;
  endtask

  task automatic req(input logic [31:0] va, input logic [1:0] kind,
                     input logic flat, input logic test, input logic [7:0] rq);
    tick();
    set_req(va, kind, flat, test, rq);
  endtask

  // monitor: pop one expectation per response
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (rsp_valid_o) begin
        if (exp_q.size() == 0) check(1'b0, "R8 unexpected response", 32'(rsp_valid_o), 0);
        else begin
          exp_t e;
          string tag;
          e = exp_q.pop_front();
          tag = $sformatf("R%0d", e.req);
          check(rsp_fault_o == e.fault, {tag, " fault"}, 32'(rsp_fault_o), 32'(e.fault));
          check(rsp_paddr_o == e.pa, {tag, " paddr"}, 32'(rsp_paddr_o), 32'(e.pa));
        end
      end else if (rsp_fault_o) check(1'b0, "R8 fault without valid", 1, 0);
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    check(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin sh_v[i] = 0; sh_base[i] = 0; sh_lim[i] = 0; sh_wr[i] = 0; end
    for (int i = 0; i < 4; i++) sh_win[i] = 0;
    repeat (3) @(negedge clk_i);
    // R1: reset state at the ports
    check(rsp_valid_o == 1'b0, "R1 valid in reset", 32'(rsp_valid_o), 0);
    check(rsp_fault_o == 1'b0, "R1 fault in reset", 32'(rsp_fault_o), 0);
    rst_ni = 1'b1;
    // R1: all windows point at entry 0, which is invalid
    req(32'h0000_0000, 2'b01, 1'b0, 1'b0, 1);
    req(32'h0000_C000, 2'b01, 1'b0, 1'b0, 1);
    req(32'h0000_0000, 2'b01, 1'b1, 1'b0, 1);

    tick(); set_tbl(0, 1, 24'h10_0000, 14'h3FFF, 1);
    tick(); set_tbl(1, 1, 24'h20_0000, 14'h0FFF, 0);
    tick(); set_tbl(2, 1, 24'h31_0000, 14'h3FFF, 1);
    tick(); set_tbl(5, 1, 24'h05_0000, 14'h3FFF, 1);
    tick(); set_win(0, 2);
    tick(); set_win(1, 1);
    tick(); set_win(2, 5);
    tick(); set_win(3, 3);

    // R2 window mode
    req(32'h0000_0010, 2'b01, 1'b0, 1'b0, 2);
    req(32'hABCD_8004, 2'b11, 1'b0, 1'b0, 2);
    req(32'h0000_3FFF, 2'b10, 1'b0, 1'b0, 2);
    // R7 limit boundary, write permit, invalid entry
    req(32'h0000_4FFF, 2'b01, 1'b0, 1'b0, 7);
    req(32'h0000_5000, 2'b01, 1'b0, 1'b0, 7);
    req(32'h0000_4000, 2'b10, 1'b0, 1'b0, 7);
    req(32'h0000_C000, 2'b01, 1'b0, 1'b0, 7);
    // R3 flat mode
    req(32'h0000_4010, 2'b01, 1'b1, 1'b0, 3);
    req(32'h0001_4000, 2'b10, 1'b1, 1'b0, 3);
    req(32'h0004_0000, 2'b01, 1'b1, 1'b0, 3);
    req(32'h0003_C000, 2'b01, 1'b1, 1'b0, 3);
    // R5 fetch
    req(32'h0000_0000, 2'b00, 1'b1, 1'b0, 5);
    req(32'h0000_0000, 2'b00, 1'b0, 1'b0, 5);
    // R4 interleaved back to back
    req(32'h0000_8010, 2'b01, 1'b0, 1'b0, 4);
    req(32'h0000_8010, 2'b01, 1'b1, 1'b0, 4);
    req(32'h0000_0020, 2'b01, 1'b0, 1'b0, 4);
    req(32'h0000_0020, 2'b01, 1'b1, 1'b0, 4);
    // R6 test mode
    req(32'h0000_FFFF, 2'b10, 1'b0, 1'b1, 6);
    req(32'h0001_0000, 2'b01, 1'b0, 1'b1, 6);
    req(32'h0000_1234, 2'b00, 1'b1, 1'b1, 6);
    // R9 same-cycle write sees old contents
    tick(); set_req(32'h0000_0000, 2'b01, 1'b0, 1'b0, 9); set_win(0, 5);
    req(32'h0000_0000, 2'b01, 1'b0, 1'b0, 9);
    tick(); set_req(32'h0000_C100, 2'b01, 1'b0, 1'b0, 9); set_tbl(3, 1, 24'h7F_0000, 14'h00FF, 1);
    req(32'h0000_C100, 2'b01, 1'b0, 1'b0, 9);
    req(32'h0000_C0FF, 2'b10, 1'b0, 1'b0, 9);

    // R8 idle: no responses once requests stop
    tick(); tick(); tick();
    check(rsp_valid_o == 1'b0, "R8 idle valid", 32'(rsp_valid_o), 0);
    check(exp_q.size() == 0, "R8 responses outstanding", 32'(exp_q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule